// File: doc/BRIEF.md
# Balanced Ternary Word ALU

This block is a purely combinational arithmetic and logic unit for words of balanced ternary digits. Each digit takes one of the values minus, zero or plus. It travels on a pair of binary wires, so a word of `WIDTH` digits occupies `2*WIDTH` bits. Two operand words and a four-bit operation code go in. One result word comes out, together with a separate carry digit and a flag that reports a malformed operand.

The unit offers three digit-wise inverters and three digit-wise exclusive-or flavours. Two of these are compatible with binary exclusive-or and one is modulo 3. It also offers a digit-wise AND, ripple addition, word negation and subtraction. Subtraction negates the second operand and feeds it to the same ripple adder. There are no clocked states, so the house state-machine form reduces to one operation decode. Every output follows its inputs within the same cycle.

Top module: `bt_alu`

## Requirements
- R1: Digit pair encoding: minus is `01`, zero is `00`, plus is `10`, and `11` is illegal. When both operands contain only legal pairs, `illegal_flag` is 0 and every result pair is legal.
- R2: Op code 0 (standard inverter) maps each digit of operand A as follows: minus goes to plus, zero stays zero, plus goes to minus. The carry is zero.
- R3: Op code 1 (positive-biased inverter) maps each digit of A as follows: minus and zero go to plus, plus goes to minus. Op code 2 (negative-biased inverter) maps each digit as follows: minus goes to plus, zero and plus go to minus. The carry is zero for both.
- R4: Op code 3 (equality exclusive-or) gives minus where the two digits are equal, zero/zero included, and plus where they differ. The carry is zero.
- R5: Op code 4 (strict exclusive-or) gives minus for equal non-zero digits and plus for unequal non-zero digits. It gives zero when either digit is zero. The carry is zero.
- R6: Op code 5 (modulo-3 difference) gives, per digit, the balanced residue of (A digit − B digit) mod 3. A residue of 0 gives zero, 1 gives plus and 2 gives minus. The carry is zero.
- R7: Op code 6 (digit AND) gives minus where both digits are minus, plus where both are plus, and zero otherwise. The carry is zero.
- R8: Op code 7 (add) gives a result word and carry digit such that value(result) + 3^WIDTH × value(carry) equals value(A) + value(B).
- R9: Op code 8 (negate) gives value(result) = −value(A) by swapping minus and plus in every digit. The carry is zero.
- R10: Op code 9 (subtract) gives value(result) + 3^WIDTH × value(carry) = value(A) − value(B).
- R11: If any digit pair of A or B is `11`, `illegal_flag` is 1 and the result and carry are all zero bits, whatever the op code.
- R12: Op codes 10 to 15 give an all-zero result and carry, with `illegal_flag` reflecting only the operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code (0..9 defined) |
| opnd_a | input | 2*WIDTH | Operand A, digit pairs, least significant digit in bits [1:0] |
| opnd_b | input | 2*WIDTH | Operand B, same layout |
| result | output | 2*WIDTH | Result word in the same digit layout |
| carry_out | output | 2 | Final carry digit of add or subtract, zero otherwise |
| illegal_flag | output | 1 | High when either operand holds a `11` pair |

## Verification
The bench builds two copies of the unit. One has `WIDTH` = 3, which makes a complete sweep possible: all 27 × 27 legal operand pairs under all ten defined op codes, so every digit combination and every carry ripple through the whole word is seen. The other uses the default `WIDTH` = 6. It exercises add, subtract and negate with operands that reach both ends of the ±364 range, so the carry digit leaves the word in both directions. Injected `11` pairs at each digit position, and the undefined op codes, cover the error and fallback paths on the narrow copy.

// File: rtl/bt_pkg.sv
package bt_pkg;

    localparam logic [1:0] TRIT_NEG  = 2'b01;
    localparam logic [1:0] TRIT_ZERO = 2'b00;
    localparam logic [1:0] TRIT_POS  = 2'b10;
    localparam logic [1:0] TRIT_BAD  = 2'b11;

    typedef enum logic [3:0] {
        OP_TNOT = 4'd0,
        OP_PNOT = 4'd1,
        OP_NNOT = 4'd2,
        OP_XORA = 4'd3,
        OP_XORB = 4'd4,
        OP_XORM = 4'd5,
        OP_AND  = 4'd6,
        OP_ADD  = 4'd7,
        OP_NEG  = 4'd8,
        OP_SUB  = 4'd9
    } bt_op_e;

    // Digit pair to signed value (-1, 0, +1); the illegal pair reads as 0.
    function automatic logic signed [2:0] trit_to_int(input logic [1:0] t);
        logic signed [2:0] v;
        case (t)
            TRIT_NEG: v = -3'sd1;
            TRIT_POS: v = 3'sd1;
            default:  v = 3'sd0;
        endcase
        return v;
    endfunction

    // Signed value to digit pair, sign only.
    function automatic logic [1:0] int_to_trit(input logic signed [2:0] v);
        logic [1:0] t;
        if (v < 0)
            t = TRIT_NEG;
        else if (v > 0)
            t = TRIT_POS;
        else
            t = TRIT_ZERO;
        return t;
    endfunction

    // Swapping the two wires exchanges minus and plus and keeps zero.
    function automatic logic [1:0] trit_swap(input logic [1:0] t);
        return {t[0], t[1]};
    endfunction

endpackage

// File: rtl/bt_trit_cell.sv
module bt_trit_cell
    import bt_pkg::*;
(
    input  bt_op_e     op,
    input  logic [1:0] x,
    input  logic [1:0] y,
    output logic [1:0] z
);

    logic signed [2:0] xv;
    logic signed [2:0] yv;
    logic signed [2:0] dv;

    always_comb begin
        xv = trit_to_int(x);
        yv = trit_to_int(y);
        dv = xv - yv;
        z  = TRIT_ZERO;
        case (op)
            OP_TNOT, OP_NEG: begin
                z = trit_swap(x);
            end
            OP_PNOT: begin
                z = (x == TRIT_POS) ? TRIT_NEG : TRIT_POS;
            end
            OP_NNOT: begin
                z = (x == TRIT_NEG) ? TRIT_POS : TRIT_NEG;
            end
            OP_XORA: begin
                z = (x == y) ? TRIT_NEG : TRIT_POS;
            end
            OP_XORB: begin
                if (x == TRIT_ZERO || y == TRIT_ZERO)
                    z = TRIT_ZERO;
                else
                    z = (x == y) ? TRIT_NEG : TRIT_POS;
            end
            OP_XORM: begin
                if (dv == 3'sd2)
                    z = TRIT_NEG;
                else if (dv == -3'sd2)
                    z = TRIT_POS;
                else
                    z = int_to_trit(dv);
            end
            OP_AND: begin
                z = (x == y) ? x : TRIT_ZERO;
            end
            default: begin
                z = TRIT_ZERO;
            end
        endcase
    end

endmodule

// File: rtl/bt_full_add.sv
module bt_full_add
    import bt_pkg::*;
(
    input  logic [1:0] a,
    input  logic [1:0] b,
    input  logic [1:0] ci,
    output logic [1:0] s,
    output logic [1:0] co
);

    int tot;

    always_comb begin
        tot = int'(trit_to_int(a)) + int'(trit_to_int(b)) + int'(trit_to_int(ci));
        case (tot)
            -3: begin s = TRIT_ZERO; co = TRIT_NEG;  end
            -2: begin s = TRIT_POS;  co = TRIT_NEG;  end
            -1: begin s = TRIT_NEG;  co = TRIT_ZERO; end
             1: begin s = TRIT_POS;  co = TRIT_ZERO; end
             2: begin s = TRIT_NEG;  co = TRIT_POS;  end
             3: begin s = TRIT_ZERO; co = TRIT_POS;  end
            default: begin s = TRIT_ZERO; co = TRIT_ZERO; end
        endcase
    end

endmodule

// File: rtl/bt_ripple_add.sv
module bt_ripple_add
    import bt_pkg::*;
#(
    parameter int WIDTH = 6
) (
    input  logic [2*WIDTH-1:0] a,
    input  logic [2*WIDTH-1:0] b,
    output logic [2*WIDTH-1:0] sum,
    output logic [1:0]         cout
);

    localparam int CHAIN_BITS = 2 * (WIDTH + 1);

    logic [CHAIN_BITS-1:0] chain;

    assign chain[1:0] = TRIT_ZERO;

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        bt_full_add u_fa (
            .a  (a[2*i +: 2]),
            .b  (b[2*i +: 2]),
            .ci (chain[2*i +: 2]),
            .s  (sum[2*i +: 2]),
            .co (chain[2*(i+1) +: 2])
        );
    end

    assign cout = chain[2*WIDTH +: 2];

endmodule

// File: rtl/bt_alu.sv
module bt_alu
    import bt_pkg::*;
#(
    parameter int WIDTH = 6
) (
    input  logic [3:0]         op_sel,
    input  logic [2*WIDTH-1:0] opnd_a,
    input  logic [2*WIDTH-1:0] opnd_b,
    output logic [2*WIDTH-1:0] result,
    output logic [1:0]         carry_out,
    output logic               illegal_flag
);

    localparam int BITS = 2 * WIDTH;

    bt_op_e           op;
    logic [WIDTH-1:0] bad_vec;
    logic [BITS-1:0]  logic_word;
    logic [BITS-1:0]  b_inv;
    logic [BITS-1:0]  add_b;
    logic [BITS-1:0]  add_sum;
    logic [1:0]       add_cout;

    assign op = bt_op_e'(op_sel);

    for (genvar i = 0; i < WIDTH; i++) begin : g_digit
        assign bad_vec[i] = (opnd_a[2*i +: 2] == TRIT_BAD) ||
                            (opnd_b[2*i +: 2] == TRIT_BAD);
        assign b_inv[2*i +: 2] = trit_swap(opnd_b[2*i +: 2]);

        bt_trit_cell u_cell (
            .op (op),
            .x  (opnd_a[2*i +: 2]),
            .y  (opnd_b[2*i +: 2]),
            .z  (logic_word[2*i +: 2])
        );
    end

    assign add_b = (op == OP_SUB) ? b_inv : opnd_b;

    bt_ripple_add #(.WIDTH(WIDTH)) u_add (
        .a    (opnd_a),
        .b    (add_b),
        .sum  (add_sum),
        .cout (add_cout)
    );

    assign illegal_flag = |bad_vec;

    always_comb begin
        result    = '0;
        carry_out = TRIT_ZERO;
        if (!illegal_flag) begin
            case (op)
                OP_ADD, OP_SUB: begin
                    result    = add_sum;
                    carry_out = add_cout;
                end
                OP_TNOT, OP_PNOT, OP_NNOT, OP_XORA, OP_XORB,
                OP_XORM, OP_AND, OP_NEG: begin
                    result    = logic_word;
                    carry_out = TRIT_ZERO;
                end
                default: begin
                    result    = '0;
                    carry_out = TRIT_ZERO;
                end
            endcase
        end
    end

endmodule

// File: rtl/bt_alu_chk.sv
module bt_alu_chk
    import bt_pkg::*;
#(
    parameter int WIDTH = 6
) (
    input logic [3:0]         op_sel,
    input logic [2*WIDTH-1:0] opnd_a,
    input logic [2*WIDTH-1:0] opnd_b,
    input logic [2*WIDTH-1:0] result,
    input logic [1:0]         carry_out,
    input logic               illegal_flag
);

    function automatic longint pow3(input int n);
        longint p;
        p = 1;
        for (int k = 0; k < n; k++) p = p * 3;
        return p;
    endfunction

    function automatic longint word_val(input logic [2*WIDTH-1:0] w);
        longint acc;
        acc = 0;
        for (int k = WIDTH - 1; k >= 0; k--)
            acc = acc * 3 + longint'(trit_to_int(w[2*k +: 2]));
        return acc;
    endfunction

    function automatic logic has_bad(input logic [2*WIDTH-1:0] w);
        logic f;
        f = 1'b0;
        for (int k = 0; k < WIDTH; k++)
            if (w[2*k +: 2] == TRIT_BAD) f = 1'b1;
        return f;
    endfunction

    localparam longint SPAN = pow3(WIDTH);

    longint va, vb, vr, vc;

    always_comb begin
        va = word_val(opnd_a);
        vb = word_val(opnd_b);
        vr = word_val(result);
        vc = longint'(trit_to_int(carry_out));

        assert_zero_on_bad_R11: assert (!illegal_flag || (result == '0 && carry_out == 2'b00));

        assert_legal_output_R1: assert (illegal_flag || (!has_bad(result) && carry_out != TRIT_BAD));

        if (!illegal_flag && op_sel == 4'd7) begin
            assert_add_value_R8: assert (vr + SPAN * vc == va + vb);
        end

        if (!illegal_flag && op_sel == 4'd9) begin
            assert_sub_value_R10: assert (vr + SPAN * vc == va - vb);
        end

        if (!illegal_flag && op_sel == 4'd8) begin
            assert_neg_value_R9: assert (vr == -va && carry_out == 2'b00);
        end

        if (!illegal_flag && op_sel >= 4'd10) begin
            assert_unused_zero_R12: assert (result == '0 && carry_out == 2'b00);
        end
    end

endmodule

bind bt_alu bt_alu_chk #(.WIDTH(WIDTH)) u_bt_alu_chk (
    .op_sel       (op_sel),
    .opnd_a       (opnd_a),
    .opnd_b       (opnd_b),
    .result       (result),
    .carry_out    (carry_out),
    .illegal_flag (illegal_flag)
);

// File: tb/test_bt_alu.sv
module test_bt_alu;

    localparam int NW = 3;
    localparam int WW = 6;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    logic [3:0]      n_op;
    logic [2*NW-1:0] n_a, n_b, n_res;
    logic [1:0]      n_c;
    logic            n_f;

    logic [3:0]      w_op;
    logic [2*WW-1:0] w_a, w_b, w_res;
    logic [1:0]      w_c;
    logic            w_f;

    bt_alu #(.WIDTH(NW)) i_bt_alu (
        .op_sel(n_op), .opnd_a(n_a), .opnd_b(n_b),
        .result(n_res), .carry_out(n_c), .illegal_flag(n_f)
    );

    bt_alu #(.WIDTH(WW)) i_bt_alu_wide (
        .op_sel(w_op), .opnd_a(w_a), .opnd_b(w_b),
        .result(w_res), .carry_out(w_c), .illegal_flag(w_f)
    );

    // ---- bench-side balanced ternary model ----
    function automatic logic [1:0] dig_enc(input int d);
        return (d < 0) ? 2'b01 : (d > 0) ? 2'b10 : 2'b00;
    endfunction

    function automatic int dig_dec(input logic [1:0] p);
        return (p == 2'b01) ? -1 : (p == 2'b10) ? 1 : 0;
    endfunction

    function automatic logic [11:0] enc(input int v, input int w);
        logic [11:0] r;
        int x, m, d;
        r = '0;
        x = v;
        for (int i = 0; i < w; i++) begin
            m = ((x % 3) + 3) % 3;
            d = (m == 2) ? -1 : m;
            r[2*i +: 2] = dig_enc(d);
            x = (x - d) / 3;
        end
        return r;
    endfunction

    function automatic int digit_op(input int op, input int x, input int y);
        int m;
        case (op)
            0: return -x;
            1: return (x == 1) ? -1 : 1;
            2: return (x == -1) ? 1 : -1;
            3: return (x == y) ? -1 : 1;
            4: return (x == 0 || y == 0) ? 0 : ((x == y) ? -1 : 1);
            5: begin m = (((x - y) % 3) + 3) % 3; return (m == 2) ? -1 : m; end
            6: return (x == y) ? x : 0;
            8: return -x;
            default: return 0;
        endcase
    endfunction

    function automatic string req_of(input int op);
        case (op)
            0: return "R2";
            1, 2: return "R3";
            3: return "R4";
            4: return "R5";
            5: return "R6";
            6: return "R7";
            7: return "R8";
            8: return "R9";
            9: return "R10";
            default: return "R12";
        endcase
    endfunction

    task automatic report(input string req, input logic [11:0] act_r, input logic [1:0] act_c,
                          input logic act_f, input logic [11:0] exp_r, input logic [1:0] exp_c,
                          input logic exp_f);
        n_tests++;
        if (act_r !== exp_r || act_c !== exp_c || act_f !== exp_f) begin
            n_fail++;
            $display("FAIL %s: result=%h carry=%b flag=%b expected result=%h carry=%b flag=%b",
                     req, act_r, act_c, act_f, exp_r, exp_c, exp_f);
        end
    endtask

    // expected result word and carry for legal operands
    task automatic model(input int op, input int a, input int b, input int w,
                         output logic [11:0] er, output logic [1:0] ec);
        int half, span, tot, cy;
        logic [11:0] ea, eb;
        span = 1;
        for (int i = 0; i < w; i++) span = span * 3;
        half = (span - 1) / 2;
        er = '0;
        ec = 2'b00;
        if (op == 7 || op == 9) begin
            tot = (op == 7) ? a + b : a - b;
            cy = 0;
            if (tot > half) begin tot = tot - span; cy = 1; end
            if (tot < -half) begin tot = tot + span; cy = -1; end
            er = enc(tot, w);
            ec = dig_enc(cy);
        end else if (op <= 8) begin
            ea = enc(a, w);
            eb = enc(b, w);
            for (int i = 0; i < w; i++)
                er[2*i +: 2] = dig_enc(digit_op(op, dig_dec(ea[2*i +: 2]), dig_dec(eb[2*i +: 2])));
        end
    endtask

    task automatic run_narrow(input int op, input int a, input int b);
        logic [11:0] er;
        logic [1:0]  ec;
        n_op = 4'(op);
        n_a  = enc(a, NW)[2*NW-1:0];
        n_b  = enc(b, NW)[2*NW-1:0];
        #5;
        model(op, a, b, NW, er, ec);
        report(req_of(op), {6'b0, n_res}, n_c, n_f, er, ec, 1'b0);  // flag low: R1
    endtask

    task automatic run_wide(input int op, input int a, input int b);
        logic [11:0] er;
        logic [1:0]  ec;
        w_op = 4'(op);
        w_a  = enc(a, WW);
        w_b  = enc(b, WW);
        #5;
        model(op, a, b, WW, er, ec);
        report(req_of(op), w_res, w_c, w_f, er, ec, 1'b0);
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!done && cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        n_op = '0; n_a = '0; n_b = '0;
        w_op = '0; w_a = '0; w_b = '0;
        #5;
        // reset-state check: zero operands, op 0 gives zero word, no flag (R1, R2)
        report("R1", {6'b0, n_res}, n_c, n_f, 12'h000, 2'b00, 1'b0);

        // R1..R10: exhaustive narrow sweep over every legal pair and op
        for (int op = 0; op < 10; op++)
            for (int a = -13; a <= 13; a++)
                for (int b = -13; b <= 13; b++)
                    run_narrow(op, a, b);

        // R12: undefined op codes
        for (int op = 10; op < 16; op++) begin
            run_narrow(op, 13, -13);
            run_narrow(op, 5, 7);
        end

        // R11: illegal pair at each position of A and of B
        for (int pos = 0; pos < NW; pos++) begin
            for (int op = 0; op < 16; op += 3) begin
                n_op = 4'(op);
                n_a = enc(4, NW)[2*NW-1:0];
                n_b = enc(-2, NW)[2*NW-1:0];
                n_a[2*pos +: 2] = 2'b11;
                #5;
                report("R11", {6'b0, n_res}, n_c, n_f, 12'h000, 2'b00, 1'b1);
                n_a = enc(4, NW)[2*NW-1:0];
                n_b[2*pos +: 2] = 2'b11;
                #5;
                report("R11", {6'b0, n_res}, n_c, n_f, 12'h000, 2'b00, 1'b1);
            end
        end

        // R8, R9, R10 on the default width, including both carry directions
        for (int a = -364; a <= 364; a += 13) begin
            run_wide(7, a, 364);
            run_wide(7, a, -364);
            run_wide(7, a, 1);
            run_wide(9, a, 364);
            run_wide(9, a, -364);
            run_wide(9, a, -1);
            run_wide(8, a, 0);
        end
        run_wide(7, 364, 364);
        run_wide(7, -364, -364);
        run_wide(9, -364, 364);
        run_wide(8, 8, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule